// File: doc/BRIEF.md
# Three-Port Pin Interrupt Unit

The unit watches three byte-wide groups of input pins (ports 0, 1 and 2) and raises interrupts when pins show a programmed condition. Each pin is set up by two configuration bits, one picking level or edge sensing and one picking the active sense (high/rising or low/falling). Edge events are held until software clears them. Level conditions follow the pin as it is now. Every pin has its own enable bit and an optional debounce filter.

Port 0 and port 1 share one combined interrupt line. Port 2 drives eight separate lines, one for each pin. Software reaches the configuration, clear and status bytes through a simple byte bus: a write strobe with address and data, and read data that is decoded from the address with no clock delay. To sense both edges, software inverts the sense bit after each event.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held and right after it, every sense, mode, enable and filter byte reads 0x00 and no interrupt output is high. Because the pins are low, each status byte reads 0xFF at that point, since level-low is the reset mode.
- R2: A pin whose mode bit is 0 reports status 1 while its synchronized input equals its sense bit. A sense bit of 1 means high and 0 means low. This status is not held: it drops when the pin returns.
- R3: A pin whose mode bit is 1 sets a held status bit on a rising input edge when its sense bit is 1, or on a falling edge when its sense bit is 0. The edge of the other direction leaves the status unchanged.
- R4: A write to a port's clear byte zeroes the held edge status only for the bit positions written as 1. All other held bits stay set.
- R5: A status bit reaches an interrupt output only while that pin's enable bit is 1. The status byte reads the same whatever the enable bits are.
- R6: The combined line is the OR of all enabled status bits of ports 0 and 1. Bit i of the port-2 output vector is the enabled status of port-2 pin i, and port 2 never drives the combined line.
- R7: With a pin's filter bit set, a new input value is accepted only after it has been stable for DEB_CYCLES clocks (default 4), so a 2-clock pulse produces no event. With the filter bit clear, the same pulse is detected.
- R8: Writing a sense bit creates no event by itself. After the bit is inverted, the edge of the new direction is detected, which gives both-edge operation.
- R9: Byte addresses in port order 0/1/2: mode 0x90/0xAC/0x4C, sense 0x94/0xB0/0x50, clear 0x98/0xB4/0x54, enable 0x9C/0xB8/0x58, filter 0xA8/0xC4/0x64, status 0xA0/0xBC/0x5C. Configuration bytes read back as written, and writes to a status byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 24 | Pins; port p uses bits 8p+7..8p |
| irq_shared | output | 1 | Combined interrupt for ports 0 and 1 |
| irq_pin2 | output | 8 | Per-pin interrupts of port 2 |

## Verification
A wrong held edge bit shows up at the outputs on the first clock after the bad event or clear: an interrupt line stays high after a clear, or never rises after a matching edge. A wrong synchronizer or filter count shows up within a few clocks as a short pulse that gets through, or as a long pulse that is missed. Both are seen by reading the status byte and by watching the lines after enable. Sense writes with no pin change, and pulses in the opposite direction, expose a detector that keys on configuration instead of on samples.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT  = 3;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_SENSE, SEL_CLEAR, SEL_ENABLE, SEL_FILTER, SEL_STATUS
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e    sel;
    logic [1:0]  port;
  } reg_dec_t;

  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_dec_t d;
    d.sel  = SEL_NONE;
    d.port = 2'd0;
    case (a)
      8'h90: begin d.sel = SEL_MODE;   d.port = 2'd0; end
      8'hAC: begin d.sel = SEL_MODE;   d.port = 2'd1; end
      8'h4C: begin d.sel = SEL_MODE;   d.port = 2'd2; end
      8'h94: begin d.sel = SEL_SENSE;  d.port = 2'd0; end
      8'hB0: begin d.sel = SEL_SENSE;  d.port = 2'd1; end
      8'h50: begin d.sel = SEL_SENSE;  d.port = 2'd2; end
      8'h98: begin d.sel = SEL_CLEAR;  d.port = 2'd0; end
      8'hB4: begin d.sel = SEL_CLEAR;  d.port = 2'd1; end
      8'h54: begin d.sel = SEL_CLEAR;  d.port = 2'd2; end
      8'h9C: begin d.sel = SEL_ENABLE; d.port = 2'd0; end
      8'hB8: begin d.sel = SEL_ENABLE; d.port = 2'd1; end
      8'h58: begin d.sel = SEL_ENABLE; d.port = 2'd2; end
      8'hA8: begin d.sel = SEL_FILTER; d.port = 2'd0; end
      8'hC4: begin d.sel = SEL_FILTER; d.port = 2'd1; end
      8'h64: begin d.sel = SEL_FILTER; d.port = 2'd2; end
      8'hA0: begin d.sel = SEL_STATUS; d.port = 2'd0; end
      8'hBC: begin d.sel = SEL_STATUS; d.port = 2'd1; end
      8'h5C: begin d.sel = SEL_STATUS; d.port = 2'd2; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/gpio_irq_pin_filter.sv
module gpio_irq_pin_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic filt_en,
  output logic pin_clean
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          s1_q, s2_q, filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!filt_en) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else if (s2_q == filt_q) begin
      cnt_d  = '0;
    end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= pin_raw;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pin_clean = filt_en ? filt_q : s2_q;

  AST_FILTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && (filt_q != $past(filt_q))) |-> ($past(s2_q) == filt_q)); // R7
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PW         = 8,
  parameter int DEB_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pins,
  input  logic          wr_mode,
  input  logic          wr_sense,
  input  logic          wr_clear,
  input  logic          wr_enable,
  input  logic          wr_filter,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] mode_q,
  output logic [PW-1:0] sense_q,
  output logic [PW-1:0] enable_q,
  output logic [PW-1:0] filter_q,
  output logic [PW-1:0] status,
  output logic [PW-1:0] irq_vec
);
  logic [PW-1:0] clean, prev_q, held_q, held_d, evt, rise, fall, level_hit, clr_mask;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    gpio_irq_pin_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (pins[i]),
      .filt_en  (filter_q[i]),
      .pin_clean(clean[i])
    );
  end

  always_comb begin
    rise      = clean & ~prev_q;
    fall      = ~clean & prev_q;
    evt       = mode_q & ((sense_q & rise) | (~sense_q & fall));
    clr_mask  = wr_clear ? wdata : '0;
    held_d    = (held_q & ~clr_mask) | evt;
    level_hit = ~(clean ^ sense_q);
    status    = (mode_q & held_q) | (~mode_q & level_hit);
    irq_vec   = status & enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      held_q   <= '0;
      mode_q   <= '0;
      sense_q  <= '0;
      enable_q <= '0;
      filter_q <= '0;
    end else begin
      prev_q <= clean;
      held_q <= held_d;
      if (wr_mode)   mode_q   <= wdata;
      if (wr_sense)  sense_q  <= wdata;
      if (wr_enable) enable_q <= wdata;
      if (wr_filter) filter_q <= wdata;
    end
  end

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((held_q & $past(wdata & ~evt)) == '0)); // R4
  AST_HELD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clear |=> (($past(held_q) & ~held_q) == '0)); // R3
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int DEB_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wen,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [23:0] pin_in,
  output logic        irq_shared,
  output logic [7:0]  irq_pin2
);
  import gpio_irq_pkg::*;

  logic     rs1_q, rs2_q;
  reg_dec_t dec;

  logic [PORT_W-1:0] mode_v   [NPORT];
  logic [PORT_W-1:0] sense_v  [NPORT];
  logic [PORT_W-1:0] enable_v [NPORT];
  logic [PORT_W-1:0] filter_v [NPORT];
  logic [PORT_W-1:0] status_v [NPORT];
  logic [PORT_W-1:0] irq_v    [NPORT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign dec = decode_addr(bus_addr);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = bus_wen && (dec.port == 2'(p));
    gpio_irq_port #(.PW(PORT_W), .DEB_CYCLES(DEB_CYCLES)) u_port (
      .clk      (clk),
      .rst_n    (rs2_q),
      .pins     (pin_in[p*PORT_W +: PORT_W]),
      .wr_mode  (hit && dec.sel == SEL_MODE),
      .wr_sense (hit && dec.sel == SEL_SENSE),
      .wr_clear (hit && dec.sel == SEL_CLEAR),
      .wr_enable(hit && dec.sel == SEL_ENABLE),
      .wr_filter(hit && dec.sel == SEL_FILTER),
      .wdata    (bus_wdata),
      .mode_q   (mode_v[p]),
      .sense_q  (sense_v[p]),
      .enable_q (enable_v[p]),
      .filter_q (filter_v[p]),
      .status   (status_v[p]),
      .irq_vec  (irq_v[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (dec.port < 2'(NPORT)) begin
      case (dec.sel)
        SEL_MODE:   bus_rdata = mode_v[dec.port];
        SEL_SENSE:  bus_rdata = sense_v[dec.port];
        SEL_ENABLE: bus_rdata = enable_v[dec.port];
        SEL_FILTER: bus_rdata = filter_v[dec.port];
        SEL_STATUS: bus_rdata = status_v[dec.port];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_shared = |(irq_v[0] | irq_v[1]);
  assign irq_pin2   = irq_v[2];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_shared && irq_pin2 == '0)); // R1
  AST_SHARED_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> ((enable_v[0] | enable_v[1]) != '0)); // R5
  AST_PIN2_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin2 & ~enable_v[2]) == '0); // R6
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  logic        clk, rst_n, bus_wen;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata, irq_pin2;
  logic [23:0] pin_in;
  logic        irq_shared;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    bit         is_rd;
    logic [7:0] exp8;
    logic       exp1;
  } item_t;
  item_t q[$];

  gpio_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .irq_shared(irq_shared), .irq_pin2(irq_pin2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.is_rd) begin
        if (bus_rdata !== it.exp8) begin
          failures++;
          $display("FAIL %s read got=%02h exp=%02h", it.tag, bus_rdata, it.exp8);
        end
      end else if (irq_shared !== it.exp1 || irq_pin2 !== it.exp8) begin
        failures++;
        $display("FAIL %s irq got=%b/%02h exp=%b/%02h", it.tag, irq_shared, irq_pin2,
                 it.exp1, it.exp8);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic exp_rd(input string tag, input logic [7:0] a, input logic [7:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    q.push_back('{tag, 1'b1, v, 1'b0});
    @(posedge clk); #1;
  endtask

  task automatic exp_irq(input string tag, input logic s, input logic [7:0] p2);
    q.push_back('{tag, 1'b0, p2, s});
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int bitn, input int len);
    @(posedge clk); #1;
    pin_in[bitn] = 1'b1;
    repeat (len) @(posedge clk);
    #1;
    pin_in[bitn] = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; bus_wen = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; pin_in = '0;
    #1 rst_n = 1'b0;
    idle(3);
    exp_irq("R1 outputs in reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    exp_irq("R1 outputs after reset", 1'b0, 8'h00);
    exp_rd("R1 mode p0", 8'h90, 8'h00);
    exp_rd("R1 sense p1", 8'hB0, 8'h00);
    exp_rd("R1 enable p2", 8'h58, 8'h00);
    exp_rd("R1 filter p1", 8'hC4, 8'h00);
    exp_rd("R1 status p0 level-low", 8'hA0, 8'hFF);
    // R9 map and read-only status
    wr(8'hAC, 8'hA5);
    exp_rd("R9 mode p1 readback", 8'hAC, 8'hA5);
    wr(8'hAC, 8'h00);
    wr(8'h5C, 8'h00);
    exp_rd("R9 status p2 write ignored", 8'h5C, 8'hFF);
    // R2 level high and low on port 0 pin 0
    wr(8'h94, 8'h01);
    wr(8'h9C, 8'h01);
    idle(2);
    exp_irq("R2 high level idle", 1'b0, 8'h00);
    pin_in[0] = 1'b1; idle(4);
    exp_irq("R2 high level active", 1'b1, 8'h00);
    pin_in[0] = 1'b0; idle(4);
    exp_irq("R2 level not held", 1'b0, 8'h00);
    wr(8'h94, 8'h00); idle(1);
    exp_irq("R2 low level active", 1'b1, 8'h00);
    wr(8'h9C, 8'h00);
    // R3 edges on port 2: pins 0-3 rising, 4-7 falling
    wr(8'h4C, 8'hFF);
    wr(8'h50, 8'h0F);
    wr(8'h54, 8'hFF);
    wr(8'h58, 8'hFF);
    idle(2);
    exp_irq("R3 p2 quiet", 1'b0, 8'h00);
    pin_in[17] = 1'b1; idle(5);
    exp_irq("R3 rising held R6 per-pin", 1'b0, 8'h02);
    pin_in[17] = 1'b0; idle(5);
    exp_irq("R3 falling ignored on rising pin", 1'b0, 8'h02);
    pin_in[21] = 1'b1; idle(5);
    exp_irq("R3 rising ignored on falling pin", 1'b0, 8'h02);
    pin_in[21] = 1'b0; idle(5);
    exp_irq("R3 falling held", 1'b0, 8'h22);
    // R4 selective clear
    wr(8'h54, 8'h02); idle(1);
    exp_irq("R4 clear one bit", 1'b0, 8'h20);
    exp_rd("R4 status after clear", 8'h5C, 8'h20);
    wr(8'h54, 8'h20); idle(1);
    exp_irq("R4 clear rest", 1'b0, 8'h00);
    // R5 enable gating on port 1 pin 3
    wr(8'hB0, 8'hFF);
    wr(8'hAC, 8'h08);
    wr(8'hB4, 8'h08);
    pin_in[11] = 1'b1; idle(5);
    exp_irq("R5 masked no output", 1'b0, 8'h00);
    exp_rd("R5 status visible while masked", 8'hBC, 8'h08);
    wr(8'hB8, 8'h08); idle(1);
    exp_irq("R5 R6 enabled drives shared", 1'b1, 8'h00);
    wr(8'hB4, 8'h08); idle(1);
    exp_irq("R4 cleared p1", 1'b0, 8'h00);
    // R8 both-edge by inverting sense
    pin_in[11] = 1'b0; idle(5);
    pin_in[11] = 1'b1; idle(5);
    exp_irq("R8 rising", 1'b1, 8'h00);
    wr(8'hB0, 8'hF7);
    wr(8'hB4, 8'h08);
    idle(4);
    exp_irq("R8 sense write no event", 1'b0, 8'h00);
    pin_in[11] = 1'b0; idle(5);
    exp_irq("R8 falling after invert", 1'b1, 8'h00);
    wr(8'hB4, 8'h08);
    wr(8'hB8, 8'h00);
    // R7 debounce on port 0 pin 2
    wr(8'h90, 8'h04);
    wr(8'h94, 8'h04);
    wr(8'hA8, 8'h04);
    wr(8'h98, 8'h04);
    wr(8'h9C, 8'h04);
    idle(2);
    pulse(2, 2); idle(10);
    exp_irq("R7 short pulse filtered", 1'b0, 8'h00);
    pulse(2, 8); idle(10);
    exp_irq("R7 long pulse passes", 1'b1, 8'h00);
    wr(8'h98, 8'h04); idle(1);
    exp_irq("R4 clear debounced", 1'b0, 8'h00);
    wr(8'hA8, 8'h00); idle(2);
    pulse(2, 2); idle(6);
    exp_irq("R7 short pulse unfiltered", 1'b1, 8'h00);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule